// File: doc/BRIEF.md
# Machine Interrupt Pending and Priority Selector

This block sits between the interrupt request lines of a processor subsystem and its trap controller. It registers three standard machine request lines (software, timer, external) and sixteen fast request lines into a read-only pending vector. It masks that vector with a per-source enable word and a global enable. It then offers the single most urgent request to the trap controller, together with a 32-bit cause word.

Every request line is active-high and level-sensitive. A peripheral keeps its line high until its own acknowledge mechanism clears it. For that reason the pending vector has no write path; it is only a registered copy of the live lines.

Once an entry has been offered, the block freezes its masked view until the trap controller acknowledges. After an acknowledge, it refuses to offer anything new until the interrupted program has retired at least one instruction. This keeps the program moving even when a request line is stuck high.

Top module: `irq_select_top`

## Requirements
- R1: `pending_o` is a registered copy of the request lines, updated on the next rising edge. Bit 3 is the software line, bit 7 the timer line and bit 11 the external line. Bits 31:16 hold fast channels 0..15, with channel n at bit 16+n. Every other bit reads zero.
- R2: Fast channels 0 and 15 are reserved. Their inputs are ignored, so `pending_o` bits 16 and 31 stay zero and neither channel is ever offered.
- R3: A source is offered only when its pending bit is set and the bit at the same position of `irq_enable_i` is set. The global enable `glb_ie_i` must also be high when the offer is decided.
- R4: Among the sources that pass R3, external wins over software, software wins over timer, and timer wins over any fast channel. Among fast channels, the lower channel number wins.
- R5: While `req_valid_o` is high, `req_cause_o` has bit 31 set and its low 5 bits hold the source code: 11 for external, 3 for software, 7 for timer, and 16+n for fast channel n. The remaining bits are zero. While `req_valid_o` is low, `req_cause_o` is zero.
- R6: When a request line rises, `req_valid_o` rises on the third rising edge after that and not earlier. This assumes the source is enabled, nothing is being offered and no acknowledge is pending.
- R7: Once `req_valid_o` is high, it and `req_cause_o` hold until `trap_ack_i` is seen. This holds even if the request line falls, its enable bit is cleared or `glb_ie_i` drops in the meantime.
- R8: On the rising edge after `trap_ack_i` is high while a request is offered, `req_valid_o` goes low.
- R9: After an acknowledge, no new request is offered until `retire_i` has been sampled high. With a request still pending, the new offer appears on the rising edge after the one that samples `retire_i`.
- R10: Reset clears `pending_o`, `req_valid_o` and `req_cause_o`. After reset, the first request may be offered without any prior `retire_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_irq_i | input | 1 | Machine software request line |
| tmr_irq_i | input | 1 | Machine timer request line |
| ext_irq_i | input | 1 | Machine external request line |
| fast_irq_i | input | 16 | Fast request lines, channel n on bit n |
| irq_enable_i | input | 32 | Per-source enable word, same bit positions as `pending_o` |
| glb_ie_i | input | 1 | Global machine interrupt enable |
| retire_i | input | 1 | Strobe: one instruction of the running program retired |
| trap_ack_i | input | 1 | Trap controller has entered the offered trap |
| pending_o | output | 32 | Read-only pending vector |
| req_valid_o | output | 1 | A request is being offered |
| req_cause_o | output | 32 | Cause word of the offered request |

## Verification
The situation hardest to reach from the ports is the forward-progress guarantee under a request that never drops. Showing it requires an acknowledge while the line stays high, followed by a long stretch with no retire strobe during which nothing may be offered. The bench keeps the external line high across the acknowledge, waits several cycles with `retire_i` low, and then pulses it once. It checks that the offer reappears exactly one edge after the retire edge.

A second hard case is the freeze during entry. There, the bench drops both the line and its enable bit while an offer is held and confirms the cause stays put. Priority is covered by sweeping every pair of sources.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int unsigned XLEN      = 32;
    localparam int unsigned FAST_N    = 16;
    localparam int unsigned FAST_LSB  = 16;
    localparam int unsigned SW_BIT    = 3;
    localparam int unsigned TMR_BIT   = 7;
    localparam int unsigned EXT_BIT   = 11;
    localparam int unsigned CODE_W    = $clog2(XLEN);
    localparam int unsigned NO_RANK   = 255;
    localparam logic [FAST_N-1:0] FAST_RSVD = 16'h8001;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } pick_t;

    // Priority rank of a pending-vector bit; smaller is more urgent.
    function automatic int unsigned src_rank(int unsigned b);
        if (b == EXT_BIT) return 0;
        if (b == SW_BIT)  return 1;
        if (b == TMR_BIT) return 2;
        if (b >= FAST_LSB && b < FAST_LSB + FAST_N) return 3 + (b - FAST_LSB);
        return NO_RANK;
    endfunction

endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler
    import irq_sel_pkg::*;
#(
    parameter int unsigned W   = XLEN,
    parameter int unsigned N   = FAST_N,
    parameter int unsigned LSB = FAST_LSB,
    parameter logic [N-1:0] RSVD = FAST_RSVD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sw_i,
    input  logic         tmr_i,
    input  logic         ext_i,
    input  logic [N-1:0] fast_i,
    output logic [W-1:0] pend_o
);

    typedef struct packed {
        logic [W-1:0] pend;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d            = '0;
        s_d.pend[SW_BIT]   = sw_i;
        s_d.pend[TMR_BIT]  = tmr_i;
        s_d.pend[EXT_BIT]  = ext_i;
        s_d.pend[LSB +: N] = fast_i & ~RSVD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;

    // R1: external line mirrored one edge later
    a_r1_ext_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        ext_i |=> pend_o[EXT_BIT]);
    a_r1_ext_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_i |=> !pend_o[EXT_BIT]);
    // R1: a non-reserved fast channel mirrored one edge later
    a_r1_fast_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        fast_i[1] |=> pend_o[LSB+1]);

endmodule

// File: rtl/irq_mask_buf.sv
module irq_mask_buf #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] en_i,
    input  logic         hold_i,
    output logic [W-1:0] held_o
);

    typedef struct packed {
        logic [W-1:0] held;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!hold_i) begin
            s_d.held = pend_i & en_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign held_o = s_q.held;

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
    import irq_sel_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] masked_i,
    output pick_t        pick_o
);

    always_comb begin
        int unsigned best;
        best   = NO_RANK;
        pick_o = '0;
        for (int unsigned b = 0; b < W; b++) begin
            if (masked_i[b] && (src_rank(b) < best)) begin
                best         = src_rank(b);
                pick_o.valid = 1'b1;
                pick_o.code  = CODE_W'(b);
            end
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_sel_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         glb_ie_i,
    input  pick_t        pick_i,
    input  logic         retire_i,
    input  logic         ack_i,
    output logic         active_o,
    output logic [W-1:0] cause_o
);

    typedef struct packed {
        logic              active;
        logic              gate;
        logic [CODE_W-1:0] code;
    } state_t;

    localparam state_t RST_STATE = '{active: 1'b0, gate: 1'b1, code: '0};

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.active) begin
            if (ack_i) begin
                s_d.active = 1'b0;
                s_d.gate   = 1'b0;
            end
        end else begin
            if (retire_i) begin
                s_d.gate = 1'b1;
            end
            if (glb_ie_i && s_q.gate && pick_i.valid) begin
                s_d.active = 1'b1;
                s_d.code   = pick_i.code;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RST_STATE;
        else        s_q <= s_d;
    end

    always_comb begin
        cause_o = '0;
        if (s_q.active) begin
            cause_o[W-1]        = 1'b1;
            cause_o[CODE_W-1:0] = s_q.code;
        end
    end

    assign active_o = s_q.active;

    // R5: an offered code always names a real source
    a_r5_code_is_source: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (src_rank(32'(cause_o[CODE_W-1:0])) != NO_RANK));

endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
    import irq_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_irq_i,
    input  logic              tmr_irq_i,
    input  logic              ext_irq_i,
    input  logic [FAST_N-1:0] fast_irq_i,
    input  logic [XLEN-1:0]   irq_enable_i,
    input  logic              glb_ie_i,
    input  logic              retire_i,
    input  logic              trap_ack_i,
    output logic [XLEN-1:0]   pending_o,
    output logic              req_valid_o,
    output logic [XLEN-1:0]   req_cause_o
);

    logic [XLEN-1:0] held;
    pick_t           pick;

    irq_pend_sampler #(
        .W(XLEN), .N(FAST_N), .LSB(FAST_LSB), .RSVD(FAST_RSVD)
    ) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_i   (sw_irq_i),
        .tmr_i  (tmr_irq_i),
        .ext_i  (ext_irq_i),
        .fast_i (fast_irq_i),
        .pend_o (pending_o)
    );

    irq_mask_buf #(.W(XLEN)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pending_o),
        .en_i   (irq_enable_i),
        .hold_i (req_valid_o),
        .held_o (held)
    );

    irq_prio_enc #(.W(XLEN)) u_enc (
        .masked_i (held),
        .pick_o   (pick)
    );

    irq_entry_ctrl #(.W(XLEN)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .glb_ie_i (glb_ie_i),
        .pick_i   (pick),
        .retire_i (retire_i),
        .ack_i    (trap_ack_i),
        .active_o (req_valid_o),
        .cause_o  (req_cause_o)
    );

    // Checker state: has a retire been seen since the last acknowledge
    logic seen_ret_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          seen_ret_q <= 1'b1;
        else if (trap_ack_i && req_valid_o)  seen_ret_q <= 1'b0;
        else if (retire_i)                   seen_ret_q <= 1'b1;
    end

    // R3: an offer only starts with the global enable set
    a_r3_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> $past(glb_ie_i));
    // R2: reserved channels never offered
    a_r2_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (req_cause_o[CODE_W-1:0] != CODE_W'(FAST_LSB)) &&
                        (req_cause_o[CODE_W-1:0] != CODE_W'(FAST_LSB + FAST_N - 1)));
    // R5: interrupt flag in cause word
    a_r5_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> req_cause_o[XLEN-1]);
    // R7: offer and cause held until acknowledged
    a_r7_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !trap_ack_i) |=> (req_valid_o && $stable(req_cause_o)));
    // R8: acknowledge releases the offer
    a_r8_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && trap_ack_i) |=> !req_valid_o);
    // R9: no back-to-back entries without a retired instruction
    a_r9_progress: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> seen_ret_q);

endmodule

// File: tb/test_irq_select_top.sv
module test_irq_select_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw, tmr, ext;
    logic [15:0] fast;
    logic [31:0] en;
    logic        glb, retire, ack;
    logic [31:0] pending, cause;
    logic        req_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_select_top i_irq_select_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_irq_i     (sw),
        .tmr_irq_i    (tmr),
        .ext_irq_i    (ext),
        .fast_irq_i   (fast),
        .irq_enable_i (en),
        .glb_ie_i     (glb),
        .retire_i     (retire),
        .trap_ack_i   (ack),
        .pending_o    (pending),
        .req_valid_o  (req_valid),
        .req_cause_o  (cause)
    );

    task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_pend(logic s, logic t, logic e, logic [15:0] f);
        logic [31:0] p;
        p        = '0;
        p[3]     = s;
        p[7]     = t;
        p[11]    = e;
        p[31:16] = f & ~16'h8001;
        return p;
    endfunction

    // {valid, cause}
    function automatic logic [32:0] model_pick(logic [31:0] m, logic g);
        if (!g)    return '0;
        if (m[11]) return {1'b1, 32'h8000_000B};
        if (m[3])  return {1'b1, 32'h8000_0003};
        if (m[7])  return {1'b1, 32'h8000_0007};
        for (int n = 1; n < 15; n++)
            if (m[16+n]) return {1'b1, 32'h8000_0000 | 32'(16+n)};
        return '0;
    endfunction

    task automatic src_vec(input int idx, output logic s, output logic t,
                           output logic e, output logic [15:0] f);
        s = (idx == 0);
        t = (idx == 1);
        e = (idx == 2);
        f = '0;
        if (idx >= 3) f[idx-3] = 1'b1;
    endtask

    task automatic clear_lines();
        sw = 1'b0; tmr = 1'b0; ext = 1'b0; fast = '0;
    endtask

    task automatic run_case(input logic s, input logic t, input logic e,
                            input logic [15:0] f, input logic [31:0] e_n, input logic g);
        logic [31:0] p;
        logic [32:0] x;
        @(negedge clk);
        sw = s; tmr = t; ext = e; fast = f; en = e_n; glb = g;
        repeat (2) @(negedge clk);
        chk("R6 no offer before third edge", {32'b0, req_valid}, 33'd0);
        @(negedge clk);
        p = model_pend(s, t, e, f);
        if ((f & 16'h8001) != 0) chk("R2 reserved channel ignored", {1'b0, pending}, {1'b0, p});
        else                     chk("R1 pending mirror", {1'b0, pending}, {1'b0, p});
        x = model_pick(p & e_n, g);
        chk("R3 offer gating", {32'b0, req_valid}, {32'b0, x[32]});
        chk("R4 R5 priority and cause", {1'b0, cause}, {1'b0, x[31:0]});
        if (req_valid) begin
            ack = 1'b1;
            clear_lines();
            @(negedge clk);
            ack = 1'b0;
            chk("R8 release after ack", {32'b0, req_valid}, 33'd0);
            repeat (3) @(negedge clk);
            retire = 1'b1;
            @(negedge clk);
            retire = 1'b0;
            repeat (2) @(negedge clk);
        end else begin
            clear_lines();
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic s1, t1, e1, s2, t2, e2;
        logic [15:0] f1, f2;
        rst_n = 1'b0; clear_lines(); en = '0; glb = 1'b0; retire = 1'b0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset pending", {1'b0, pending}, 33'd0);
        chk("R10 reset valid", {32'b0, req_valid}, 33'd0);
        chk("R10 reset cause", {1'b0, cause}, 33'd0);

        // Single sources, all enabled; the first offer needs no retire (R10)
        for (int i = 0; i < 19; i++) begin
            src_vec(i, s1, t1, e1, f1);
            run_case(s1, t1, e1, f1, 32'hFFFF_FFFF, 1'b1);
        end
        // Single sources, enables clear (R3)
        for (int i = 0; i < 19; i++) begin
            src_vec(i, s1, t1, e1, f1);
            run_case(s1, t1, e1, f1, 32'h0000_0000, 1'b1);
        end
        // Single sources, global enable low (R3)
        for (int i = 0; i < 19; i++) begin
            src_vec(i, s1, t1, e1, f1);
            run_case(s1, t1, e1, f1, 32'hFFFF_FFFF, 1'b0);
        end
        // Masked winner falls through to next source (R3, R4)
        run_case(1'b0, 1'b0, 1'b1, 16'h0020, ~(32'h1 << 11), 1'b1);
        // All pairs of sources (R4)
        for (int i = 0; i < 19; i++) begin
            for (int j = i + 1; j < 19; j++) begin
                src_vec(i, s1, t1, e1, f1);
                src_vec(j, s2, t2, e2, f2);
                run_case(s1 | s2, t1 | t2, e1 | e2, f1 | f2, 32'hFFFF_FFFF, 1'b1);
            end
        end

        // R7: drop line and enable while the offer is held
        @(negedge clk);
        tmr = 1'b1; en = 32'hFFFF_FFFF; glb = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 offer raised", {32'b0, req_valid}, 33'd1);
        tmr = 1'b0; en = '0; glb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 offer held", {32'b0, req_valid}, 33'd1);
        chk("R7 cause held", {1'b0, cause}, {1'b0, 32'h8000_0007});
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R8 release after held offer", {32'b0, req_valid}, 33'd0);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        repeat (3) @(negedge clk);

        // R9: permanent request, progress only after a retire
        en = 32'hFFFF_FFFF; glb = 1'b1; ext = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 first entry", {32'b0, req_valid}, 33'd1);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R9 released after ack", {32'b0, req_valid}, 33'd0);
        repeat (6) @(negedge clk);
        chk("R9 blocked without retire", {32'b0, req_valid}, 33'd0);
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        chk("R9 not yet on retire edge", {32'b0, req_valid}, 33'd0);
        @(negedge clk);
        chk("R9 re-entry after retire", {32'b0, req_valid}, 33'd1);
        chk("R9 re-entry cause", {1'b0, cause}, {1'b0, 32'h8000_000B});
        ack = 1'b1; ext = 1'b0;
        @(negedge clk);
        ack = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule